// File: doc/BRIEF.md
# Serial Pattern Round-Trip Delay Tester

This block measures how long a serial test burst takes to travel out over a line and come back. A trigger pulse, already debounced, starts a measurement. The block samples an 8-bit pattern from a parallel switch input at that moment. It then sends the pattern as a framed serial burst: one start bit of 1, then the pattern bits from the most significant bit down. The line rests at 0 between bursts.

A receiver watches the return line and waits for the start bit to come back. It counts the whole bit periods that pass from launch until the returned start bit is seen. It then captures the pattern bits that follow and compares them with the pattern that was sent. A match sets a valid flag and reports the measured delay. A mismatch, or no reply within 255 bit periods, raises an alarm. The results stay on the outputs until the next accepted trigger clears them. A lockout window of several seconds, sized from the clock frequency, keeps triggers apart.

The bit period is one cycle of a clock-enable divider that the transmitter and the receiver share. The receiver samples the return line once per period, halfway through the period, with no oversampling.

Top module: `rtd_tester`

## Requirements
- R1: After reset, the transmit line, delay, received pattern, valid flag and alarm flag are all 0.
- R2: An accepted trigger sends exactly one frame on the next bit-period boundary. The frame is a start bit of 1, followed by the 8 pattern bits with the MSB first. Each bit lasts BIT_DIV clock cycles. The line returns to 0 after the frame.
- R3: The pattern that is sent is the value on the pattern input in the cycle the trigger is accepted. Later changes to that input have no effect on the burst in flight.
- R4: After an accepted trigger, any trigger that arrives within CLK_HZ*LOCK_SEC clock cycles is ignored. It starts no frame and leaves every output unchanged.
- R5: The reported delay is the number of bit-period boundaries between the launch of the start bit and the mid-period sample that first sees 1 on the return line. A return that lags by D whole bit periods therefore reads D.
- R6: The 8 bits that follow the returned start bit are captured MSB first and presented on the received-pattern output.
- R7: When the received pattern equals the sent pattern, valid goes to 1 and alarm stays 0.
- R8: When the received pattern differs from the sent pattern, alarm goes to 1 and valid stays 0.
- R9: If no start bit returns within 255 bit periods, alarm goes to 1, valid stays 0 and the delay reads its saturated value of 255.
- R10: The result outputs hold their values until the next accepted trigger. In the cycle after that trigger, all of them read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Debounced trigger request |
| pattern_i | input | 8 | Test pattern from the switches |
| rx_i | input | 1 | Serial return line |
| tx_o | output | 1 | Serial transmit line, 0 when idle |
| delay_o | output | 8 | Measured round-trip delay, in bit periods |
| rx_pattern_o | output | 8 | Pattern captured from the return line |
| valid_o | output | 1 | The returned pattern matched |
| alarm_o | output | 1 | Mismatch or timeout |

## Verification
The assertions assume the return line can change only on bit-period boundaries of the shared divider. This matters because the mid-period sample must never land on a transition. They also assume a trigger counts only when the block is idle and the lockout has run out.

The stimulus meets these assumptions in two ways. It returns the transmit line through a model that delays it by whole multiples of BIT_DIV cycles, so a corrupted return still changes only on boundaries. It also pulses the trigger for one cycle at a time. Some of those pulses are placed inside the lockout window on purpose.

// File: rtl/rtd_pkg.sv
// Shared types for the round-trip delay tester.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package rtd_pkg;

    // Receiver progress through one returned frame
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rtd_bit_clock.sv
// Free-running divider that produces the shared bit-period strobes.
// tick_o marks the last cycle of a period, when the transmitter moves to its next bit.
// mid_o marks the middle of a period, when the receiver samples the line.
// Assumes BIT_DIV >= 2, so the two strobes never fall in the same cycle.
module rtd_bit_clock #(
    parameter int BIT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic mid_o
);
    localparam int DW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(BIT_DIV - 1);
    localparam logic [DW-1:0] HALF = DW'(BIT_DIV / 2 - 1);

    logic [DW-1:0] cnt_q;

    // Count cycles within a bit period, wrapping at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
    assign mid_o  = (cnt_q == HALF);
endmodule

// File: rtl/rtd_lockout.sv
// Trigger lockout timer. It reloads on every accepted trigger and counts down to zero.
// free_o is high once the window has expired.
// Assumes LOCK_CYC >= 2.
module rtd_lockout #(
    parameter int LOCK_CYC = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic free_o
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt_q;

    // Reload on acceptance, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (accept_i)       cnt_q <= LW'(LOCK_CYC - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign free_o = (cnt_q == '0);
endmodule

// File: rtl/rtd_framer.sv
// Serial frame transmitter: a start bit of 1, then PAT_W data bits MSB first, then idle at 0.
// The frame begins on the first tick after start_i.
// launch_o pulses in the cycle the start bit is committed to the line.
// Assumes pat_i is held steady from start_i until launch.
module rtd_framer #(
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic             tx_o,
    output logic             busy_o,
    output logic             launch_o
);
    localparam int RW = $clog2(PAT_W + 1);

    logic             armed_q;
    logic             sending_q;
    logic [PAT_W-1:0] sh_q;
    logic [RW-1:0]    left_q;

    assign launch_o = armed_q && tick_i;
    assign busy_o   = armed_q || sending_q;

    // Arm on request, then step the line through the frame one bit per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            sending_q <= 1'b0;
            sh_q      <= '0;
            left_q    <= '0;
            tx_o      <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
        end else if (launch_o) begin
            armed_q   <= 1'b0;
            sending_q <= 1'b1;
            sh_q      <= pat_i;
            left_q    <= RW'(PAT_W);
            tx_o      <= 1'b1;
        end else if (sending_q && tick_i) begin
            if (left_q != '0) begin
                tx_o   <= sh_q[PAT_W-1];
                sh_q   <= {sh_q[PAT_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end else begin
                tx_o      <= 1'b0;
                sending_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtd_deframer.sv
// Return-line receiver and delay counter.
// From launch, it counts ticks until a mid-period sample sees the start bit, then shifts in PAT_W bits.
// done_o and timeout_o are single-cycle pulses, and frame_o is valid together with done_o.
// Assumes the return line changes only on tick boundaries.
module rtd_deframer
    import rtd_pkg::*;
#(
    parameter int PAT_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             tick_i,
    input  logic             mid_i,
    input  logic             rx_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [CNT_W-1:0] delay_o,
    output logic [PAT_W-1:0] frame_o
);
    localparam int IW = $clog2(PAT_W + 1);
    localparam logic [CNT_W-1:0] DLY_MAX = '1;
    localparam logic [IW-1:0]    LAST_BIT = IW'(PAT_W - 1);

    rx_state_e        st_q;
    logic [CNT_W-1:0] dly_q;
    logic [PAT_W-1:0] sh_q;
    logic [IW-1:0]    idx_q;
    logic             seen_start;

    assign seen_start = (st_q == RX_HUNT) && mid_i && rx_i;
    assign timeout_o  = (st_q == RX_HUNT) && !seen_start && tick_i && (dly_q == DLY_MAX);
    assign done_o     = (st_q == RX_DATA) && mid_i && (idx_q == LAST_BIT);
    assign frame_o    = {sh_q[PAT_W-2:0], rx_i};
    assign busy_o     = (st_q != RX_IDLE);
    assign delay_o    = dly_q;

    // Hunt for the start bit while counting bit periods, then capture the data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            dly_q <= '0;
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    if (launch_i) begin
                        st_q  <= RX_HUNT;
                        dly_q <= '0;
                    end
                end
                RX_HUNT: begin
                    if (seen_start) begin
                        st_q  <= RX_DATA;
                        idx_q <= '0;
                    end else if (tick_i) begin
                        if (dly_q == DLY_MAX) st_q  <= RX_IDLE;
                        else                  dly_q <= dly_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (mid_i) begin
                        sh_q <= {sh_q[PAT_W-2:0], rx_i};
                        if (idx_q == LAST_BIT) st_q  <= RX_IDLE;
                        else                   idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rtd_tester.sv
// Top level of the serial pattern round-trip delay tester.
// A trigger is accepted only when the block is idle and the lockout has expired.
// Acceptance latches the switch pattern and clears the results. The framer and the
// deframer then run off the shared bit strobes, and the results are registered on completion.
// Assumes trig_i is already debounced and synchronous to clk_i.
module rtd_tester #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int LOCK_SEC = 5,
    parameter int BIT_DIV  = 50_000,
    parameter int PAT_W    = 8,
    parameter int CNT_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic [PAT_W-1:0] pattern_i,
    input  logic             rx_i,
    output logic             tx_o,
    output logic [CNT_W-1:0] delay_o,
    output logic [PAT_W-1:0] rx_pattern_o,
    output logic             valid_o,
    output logic             alarm_o
);
    localparam int LOCK_CYC = CLK_HZ * LOCK_SEC;
    localparam logic [CNT_W-1:0] DLY_SAT = '1;

    logic             tick, mid;
    logic             lock_free, idle, accept;
    logic             tx_busy, rx_busy, launch;
    logic             rx_done, rx_timeout;
    logic [CNT_W-1:0] rx_delay;
    logic [PAT_W-1:0] rx_frame;
    logic [PAT_W-1:0] sent_q;

    assign idle   = !tx_busy && !rx_busy;
    assign accept = trig_i && lock_free && idle;

    rtd_bit_clock #(.BIT_DIV(BIT_DIV)) u_clk (
        .clk(clk_i), .rst_n(rst_ni), .tick_o(tick), .mid_o(mid)
    );

    rtd_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk(clk_i), .rst_n(rst_ni), .accept_i(accept), .free_o(lock_free)
    );

    rtd_framer #(.PAT_W(PAT_W)) u_tx (
        .clk(clk_i), .rst_n(rst_ni), .start_i(accept), .tick_i(tick),
        .pat_i(sent_q), .tx_o(tx_o), .busy_o(tx_busy), .launch_o(launch)
    );

    rtd_deframer #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk_i), .rst_n(rst_ni), .launch_i(launch), .tick_i(tick),
        .mid_i(mid), .rx_i(rx_i), .busy_o(rx_busy), .done_o(rx_done),
        .timeout_o(rx_timeout), .delay_o(rx_delay), .frame_o(rx_frame)
    );

    // Latch the switch pattern on acceptance, so later switch changes cannot affect the burst
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     sent_q <= '0;
        else if (accept) sent_q <= pattern_i;
    end

    // Clear the results on acceptance, then publish them on completion or timeout
    always_ff @(posedge clk_i) begin
        if (!rst_ni || accept) begin
            delay_o      <= '0;
            rx_pattern_o <= '0;
            valid_o      <= 1'b0;
            alarm_o      <= 1'b0;
        end else if (rx_done) begin
            delay_o      <= rx_delay;
            rx_pattern_o <= rx_frame;
            valid_o      <= (rx_frame == sent_q);
            alarm_o      <= (rx_frame != sent_q);
        end else if (rx_timeout) begin
            delay_o <= DLY_SAT;
            valid_o <= 1'b0;
            alarm_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rtd_tester_chk.sv
// Property checker for rtd_tester, attached by bind below.
// It observes the ports together with the acceptance, idle and lockout state.
module rtd_tester_chk #(
    parameter int PAT_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             accept,
    input logic             idle,
    input logic             lock_free,
    input logic             tx,
    input logic             valid,
    input logic             alarm,
    input logic [CNT_W-1:0] delay,
    input logic [PAT_W-1:0] pat
);
    // R7 / R8: a result is either a match or an alarm, never both
    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && alarm));

    // R10: acceptance clears every result output
    p_clear_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!valid && !alarm && delay == '0 && pat == '0));

    // R4: a trigger during lockout starts nothing and changes no result
    p_ignore_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !lock_free && idle) |=> (idle && $stable(valid) && $stable(alarm) && $stable(pat)));

    // R4: every acceptance opens a lockout window
    p_lock_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !lock_free);

    // R2: the line rests at 0 whenever no burst is in progress
    p_tx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !tx);
endmodule

bind rtd_tester rtd_tester_chk #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .trig(trig_i), .accept(accept), .idle(idle),
    .lock_free(lock_free), .tx(tx_o), .valid(valid_o), .alarm(alarm_o),
    .delay(delay_o), .pat(rx_pattern_o)
);

// File: tb/rtd_tester_test.sv
// Directed bench for rtd_tester. A line model returns tx_o after a chosen delay,
// corrupted, or not at all.
module rtd_tester_test;
    localparam int DIV  = 4;
    localparam int HZ   = 64;
    localparam int SEC  = 5;
    localparam int LOCK = HZ * SEC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [7:0] pat_sw = 8'h00;
    logic       rx;
    logic       tx;
    logic [7:0] delay, rpat;
    logic       valid, alarm;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    // Line model: 0 loopback, 1 delayed by dly_bits periods, 2 corrupted, 3 cut
    int mode = 0;
    int dly_bits = 0;
    logic [63:0] hist = '0;

    always @(posedge clk) hist <= {hist[62:0], tx};
    assign rx = (mode == 0) ? tx :
                (mode == 1) ? hist[dly_bits*DIV-1] :
                (mode == 2) ? (hist[2*DIV-1] | hist[3*DIV-1]) : 1'b0;

    always #4 clk = ~clk;

    rtd_tester #(.CLK_HZ(HZ), .LOCK_SEC(SEC), .BIT_DIV(DIV)) uut (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .pattern_i(pat_sw), .rx_i(rx),
        .tx_o(tx), .delay_o(delay), .rx_pattern_o(rpat), .valid_o(valid), .alarm_o(alarm)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_trig(input logic [7:0] p);
        pat_sw = p;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_result();
        int n = 0;
        while (!valid && !alarm && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R7 result reached", int'(valid | alarm), 1);
    endtask

    task automatic run_and_check(input string tag, input logic [7:0] p, input int d);
        cycles(LOCK + 10);
        pulse_trig(p);
        wait_result();
        check({tag, " delay"}, delay, d);
        check({tag, " pattern"}, rpat, p);
        check({tag, " valid"}, valid, 1);
        check({tag, " alarm"}, alarm, 0);
    endtask

    // R1: outputs after reset
    task automatic t_reset();
        check("R1 tx", tx, 0);
        check("R1 delay", delay, 0);
        check("R1 pattern", rpat, 0);
        check("R1 valid", valid, 0);
        check("R1 alarm", alarm, 0);
    endtask

    // R2: frame shape on the line, sampled mid-bit
    task automatic t_frame();
        logic [8:0] exp_f = {1'b1, 8'hA5};
        int n = 0;
        mode = 0;
        cycles(LOCK + 10);
        pulse_trig(8'hA5);
        while (!tx && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            check("R2 frame bit", tx, exp_f[8-i]);
            cycles(DIV);
        end
        cycles(DIV);
        check("R2 idle after frame", tx, 0);
        wait_result();
        check("R5 loopback delay", delay, 0);
        check("R6 loopback pattern", rpat, 8'hA5);
        check("R7 loopback valid", valid, 1);
    endtask

    // R5 / R6 / R7: delayed returns, including the all-zero and all-one patterns
    task automatic t_delays();
        mode = 1; dly_bits = 3;
        run_and_check("R5 d3 zero", 8'h00, 3);
        dly_bits = 7;
        run_and_check("R5 d7 ones", 8'hFF, 7);
        mode = 0;
    endtask

    // R3: a switch change after acceptance has no effect
    task automatic t_sample();
        mode = 1; dly_bits = 1;
        cycles(LOCK + 10);
        pulse_trig(8'h3C);
        pat_sw = 8'h00;
        wait_result();
        check("R3 latched pattern", rpat, 8'h3C);
        check("R3 valid", valid, 1);
        check("R5 d1 delay", delay, 1);
        mode = 0;
    endtask

    // R8: a corrupted return raises the alarm
    task automatic t_mismatch();
        mode = 2;
        cycles(LOCK + 10);
        pulse_trig(8'h81);
        wait_result();
        check("R8 alarm", alarm, 1);
        check("R8 valid", valid, 0);
        check("R6 captured corrupt", rpat, 8'hC1);
        check("R5 corrupt delay", delay, 2);
        mode = 0;
    endtask

    // R9: no return leads to a timeout
    task automatic t_timeout();
        mode = 3;
        cycles(LOCK + 10);
        pulse_trig(8'h5A);
        wait_result();
        check("R9 alarm", alarm, 1);
        check("R9 valid", valid, 0);
        check("R9 delay saturated", delay, 255);
        cycles(200);
        check("R10 hold alarm", alarm, 1);
        mode = 0;
    endtask

    // R4 / R10: a trigger inside lockout is ignored, and a trigger after lockout clears the results
    task automatic t_lockout();
        int tx_seen = 0;
        mode = 0;
        cycles(LOCK + 10);
        pulse_trig(8'h5A);
        wait_result();
        pulse_trig(8'h11);
        for (int i = 0; i < 80; i++) begin
            if (tx) tx_seen++;
            @(negedge clk);
        end
        check("R4 no frame in lockout", tx_seen, 0);
        check("R4 pattern kept", rpat, 8'h5A);
        check("R4 valid kept", valid, 1);
        cycles(LOCK);
        pulse_trig(8'h11);
        check("R10 valid cleared", valid, 0);
        check("R10 pattern cleared", rpat, 0);
        check("R10 delay cleared", delay, 0);
        wait_result();
        check("R10 new pattern", rpat, 8'h11);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame();
        t_delays();
        t_sample();
        t_mismatch();
        t_timeout();
        t_lockout();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done_flag) begin
            done_flag = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule